// File: doc/BRIEF.md
# Banked Word-Addressed SRAM with Shared Registered Read Port

This block is a synthesizable behavioural model of a 1 Mbit static memory split into 32 equal banks. Every bank stores 128 rows, and each row is 256 bits wide. A row therefore carries eight 32-bit words. A 15-bit word address reaches any of the 32768 words. The address is decoded into a bank, a row inside that bank, and one of the eight word slots inside that row.

Read strobe, write strobe, address and write data are first captured in input registers. On the next edge only the bank named by the captured address is active. A write updates just the 32 columns of the chosen slot. A read loads the chosen slot into that bank's own output register. The banks share one output bus. Sharing is modelled as an AND-OR selection keyed by a one-hot record of which bank read last, so only that bank drives the bus. The active-bank vector is brought out so that the idling of the other banks can be observed.

Top module: `banked_sram`

## Requirements
- R1: Word address bits [14:10] select the bank, bits [9:3] select the row, and bits [2:0] select the 32-bit slot within the row. A word written at any address is read back unchanged, and words at different addresses are independent.
- R2: A read requested in cycle N (strobe high at rising edge N) puts its word on `rdata` after rising edge N+1. The word is visible from then until the next read completes.
- R3: A write replaces only the 32 bits of the addressed slot. The other seven words of the same row keep their values.
- R4: When the read and write strobes are both high at the same edge, the write is performed and no read happens, so `rdata` is unchanged.
- R5: `rdata` changes only as the result of a completed read. It holds its value across idle cycles and write cycles.
- R6: In the cycle after a read or write strobe is captured, `bank_act` is one-hot with bit k set, where k is the captured address bits [14:10]. In every other cycle `bank_act` is all zeros.
- R7: While `rst_n` is low, and directly after reset, `rdata` is zero and `bank_act` is zero.
- R8: Reads issued in consecutive cycles to different banks each deliver their own word, one per cycle, in issue order.
- R9: The lowest address 0 and the highest address 32767 are reachable and independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| rd_en | input | 1 | Read request strobe |
| wr_en | input | 1 | Write request strobe (takes priority over `rd_en`) |
| addr | input | 15 | Word address: bank [14:10], row [9:3], slot [2:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Shared registered read data |
| bank_act | output | 32 | One-hot active-bank vector for the registered access |

## Verification
The bench targets the following corner cases:
- The two extreme addresses. A decoder with a swapped or truncated field would alias address 32767 onto address 0 or onto some other word.
- A fully written row in which one slot is then overwritten. A wrong column-group decode would damage a neighbouring slot, which shows up when the other seven words are read back.
- A sweep of reads across all 32 banks in back-to-back cycles. This catches a shared-bus select that lags one read behind, or that picks the bank from the live address instead of the registered one.
- Simultaneous read and write. This catches a read that leaks onto the output when the write should win.
- Idle stretches. These catch an output that drifts or clears when no read is done.

// File: rtl/banked_sram.sv
module banked_sram #(
  parameter int BANK_BITS = 5,
  parameter int ROW_BITS  = 7,
  parameter int SLOT_BITS = 3,
  parameter int DATA_W    = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     rd_en,
  input  logic                                     wr_en,
  input  logic [BANK_BITS+ROW_BITS+SLOT_BITS-1:0]  addr,
  input  logic [DATA_W-1:0]                        wdata,
  output logic [DATA_W-1:0]                        rdata,
  output logic [(1<<BANK_BITS)-1:0]                bank_act
);
  localparam int BANKS  = 1 << BANK_BITS;
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int SLOTS  = 1 << SLOT_BITS;
  localparam int ROW_W  = DATA_W * SLOTS;
  localparam int ADDR_W = BANK_BITS + ROW_BITS + SLOT_BITS;

  logic              rd_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= rd_en;
      wr_q    <= wr_en;
      addr_q  <= addr;
      wdata_q <= wdata;
    end

  wire [BANK_BITS-1:0] bank_q = addr_q[ADDR_W-1 -: BANK_BITS];
  wire [ROW_BITS-1:0]  row_q  = addr_q[SLOT_BITS +: ROW_BITS];
  wire [SLOT_BITS-1:0] slot_q = addr_q[SLOT_BITS-1:0];
  wire                 rd_go  = rd_q & ~wr_q;

  assign bank_act = (rd_q | wr_q) ? (BANKS'(1) << bank_q) : '0;

  logic [BANKS-1:0]             out_sel;
  logic [BANKS-1:0][DATA_W-1:0] masked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     out_sel <= BANKS'(1);
    else if (rd_go) out_sel <= bank_act;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0]  mem [ROWS];
    logic [DATA_W-1:0] q_r;
    wire               en = bank_act[b];

    always_ff @(posedge clk)
      if (en && wr_q) mem[row_q][slot_q*DATA_W +: DATA_W] <= wdata_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          q_r <= '0;
      else if (en && rd_go) q_r <= mem[row_q][slot_q*DATA_W +: DATA_W];

    assign masked[b] = out_sel[b] ? q_r : '0;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) rdata = rdata | masked[b];
  end

  assert_act_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_act));
  assert_act_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q || wr_q) |-> bank_act == '0);
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(out_sel));
  assert_sel_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> out_sel == $past(bank_act));
  assert_hold_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata));
  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && wr_q) |=> $stable(out_sel));
endmodule

// File: tb/banked_sram_test.sv
module banked_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, bank_act;

  banked_sram uut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .bank_act(bank_act));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R7";
  bit done = 1'b0;

  logic [31:0] refm [int];
  bit          m_rd, m_wr;
  int          m_addr;
  logic [31:0] m_data, exp_rdata, exp_act;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nxt(logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_addr = 0; m_data = '0; exp_rdata = '0;
    end else begin
      if (m_wr) refm[m_addr] = m_data;
      else if (m_rd) exp_rdata = refm.exists(m_addr) ? refm[m_addr] : 32'hdead_beef;
      m_rd = rd_en; m_wr = wr_en; m_addr = int'(addr); m_data = wdata;
    end
    exp_act = (m_rd || m_wr) ? (32'd1 << m_addr[14:10]) : '0;
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(tag, rdata, exp_rdata);
    check("R6", bank_act, exp_act);
  end

  task automatic op(bit r, bit w, int a, logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = 15'(a); wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", rdata, '0);
    check("R7", bank_act, '0);
    rst_n = 1'b1;
    idle(2);

    tag = "R9";
    op(0, 1, 0, 32'h0000_0001);
    op(0, 1, 32767, 32'hffff_fffe);
    op(1, 0, 0, '0);
    op(1, 0, 32767, '0);
    idle(3);

    tag = "R2";
    op(0, 1, 15'h1234, 32'hcafe_f00d);
    for (int i = 0; i < 5; i++) op(1, 0, 15'h1234, '0);
    idle(3);

    tag = "R3";
    for (int s = 0; s < 8; s++) begin seed = nxt(seed); op(0, 1, (7 << 10) | (55 << 3) | s, seed); end
    op(0, 1, (7 << 10) | (55 << 3) | 5, 32'h5555_aaaa);
    for (int s = 0; s < 8; s++) op(1, 0, (7 << 10) | (55 << 3) | s, '0);
    idle(3);

    tag = "R1";
    for (int b = 0; b < 32; b++) begin seed = nxt(seed); op(0, 1, (b << 10) | (9 << 3) | 2, seed); end
    for (int b = 0; b < 32; b++) begin seed = nxt(seed); op(0, 1, (b << 10) | (100 << 3) | (b % 8), seed); end
    tag = "R8";
    for (int b = 31; b >= 0; b--) op(1, 0, (b << 10) | (9 << 3) | 2, '0);
    for (int b = 0; b < 32; b++) op(1, 0, (b << 10) | (100 << 3) | (b % 8), '0);
    idle(3);

    tag = "R4";
    op(1, 0, 0, '0);
    op(1, 1, 15'h1234, 32'h0bad_0bad);
    idle(2);
    op(1, 0, 15'h1234, '0);
    idle(3);

    tag = "R5";
    op(1, 0, 32767, '0);
    idle(6);
    op(0, 1, 32767, 32'h7777_1111);
    idle(4);
    op(1, 0, 32767, '0);
    idle(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule